// File: doc/BRIEF.md
# Non-Blocking Load Interlock Controller

This block is the pipeline control for an in-order five-stage core in which a load does not hold up the pipe for its whole memory read. A load starts when it leaves the execute stage. Later instructions keep moving while the read is in flight. The controller remembers the one register the outstanding load will write. It compares that register with the operands that the instruction in decode wants from the register file, and it stalls only on a real dependency. There are two fixed exceptions. The pipe always pauses in the cycle after a load starts, and again in the cycle the read data comes back. The second pause frees the single register-file write port for the loaded value.

The instruction directly behind a load keeps delay-slot semantics. It is already past decode when the load starts, so it is never interlocked and reads the register's previous value. Only one load may be in flight. A load waiting in execute is held until the outstanding one has written back. It is held one cycle longer if it targets the same register. Register 0 never interlocks and is never written.

The memory return `mem_rvalid` is a valid-only stream with no ready. The controller takes the data in the cycle it appears and turns it into a write-port request on `ld_wb_en`/`ld_wb_idx` in that same cycle. The pipeline's back-pressure is the `stall` output, which acts as a not-ready for decode and execute: while it is high, neither stage advances and no load may start.

Top module: `load_interlock_ctrl`

## Requirements
- R1: While and directly after reset, with all inputs idle, `stall` and `ld_wb_en` are low.
- R2: A load starts in a cycle where `ex_ld_vld` is high and `stall` is low. In the next cycle `stall` is high whatever decode holds.
- R3: In a cycle where `mem_rvalid` is high for the outstanding load, `stall` is high. In that cycle `ld_wb_en` is high and `ld_wb_idx` equals the load's destination, unless R9 or R10 applies. `ld_wb_en` is never high in any other cycle.
- R4: Decode source i is field i of `dec_src_idx`, bits [i*5 +: 5], and it counts when bit i of `dec_src_vld` is set. If a counted source equals the nonzero destination of the outstanding load, `stall` stays high up to and including the data-return cycle. The stall releases in the following cycle.
- R5: Delay slot: the instruction that leaves decode in the load's start cycle is not interlocked. With a 6-cycle memory, a load followed directly by a reader of its destination costs 3 cycles.
- R6: With memory data arriving 6 cycles after the start cycle, a load costs 8-d cycles when the first reader of its destination is d instructions behind it, for d from 1 to 5. It costs 3 cycles with no reader or with d of 5 or more. Cost is 1 plus the stall cycles the load causes.
- R7: At most one load is outstanding. A load in execute is held while another is outstanding. If the two destinations differ, it starts in the first cycle after the data-return cycle.
- R8: A load in execute whose destination equals that of the load that returned in the previous cycle is held one extra cycle. Three back-to-back loads cost 14 stall cycles with distinct destinations and 16 with one shared destination.
- R9: A load to register 0 causes no interlock and no `ld_wb_en`. It still takes both fixed stall cycles.
- R10: A regular writeback (`rf_wb_vld`, `rf_wb_dst`) to the destination of the outstanding load, in any cycle up to and including the data-return cycle, cancels that load's `ld_wb_en`. The return-cycle stall still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_ld_vld | input | 1 | Execute stage holds a load |
| ex_ld_dst | input | REG_AW | Destination register of that load |
| mem_rvalid | input | 1 | Read data for the outstanding load is valid this cycle |
| dec_src_vld | input | NUM_SRC | Per-source read flags of the decode instruction |
| dec_src_idx | input | NUM_SRC*REG_AW | Packed source register indices of the decode instruction |
| rf_wb_vld | input | 1 | A regular result is written to the register file this cycle |
| rf_wb_dst | input | REG_AW | Register of that regular write |
| stall | output | 1 | Freeze decode and execute; no load may start |
| ld_wb_en | output | 1 | Write the returned load data this cycle |
| ld_wb_idx | output | REG_AW | Register for the load write |

## Verification
The bound checker watches several rules on every cycle. It checks the guard stall after each start, the stall and the only legal timing of a load write in the return cycle, and that a decode read of the outstanding register is held. It also checks that a start never overlaps an outstanding load and that register 0 is never written. Some behaviour only shows up as cycle totals over whole instruction sequences, so only the bench's scenarios can show it. That covers the cost curve against load-to-use distance, the delay-slot exemption, the extra cycle for same-register back-to-back loads, and the cancelled write after a younger writeback.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned LIC_REG_AW  = 5;
  localparam int unsigned LIC_NUM_SRC = 2;

  // Individual reasons for a pipeline hold, kept apart for visibility.
  typedef struct packed {
    logic guard;   // fixed cycle after a load start
    logic ret;     // write-port slot for returning data
    logic dep;     // decode reads the in-flight register
    logic busy;    // second load while one is in flight
    logic space;   // same-destination spacing after a return
  } hold_why_t;
endpackage

// File: rtl/lic_pend_track.sv
module lic_pend_track #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REG_AW-1:0] start_dst,
  input  logic              rvalid,
  input  logic              rf_wb_vld,
  input  logic [REG_AW-1:0] rf_wb_dst,
  output logic              pend_vld,
  output logic [REG_AW-1:0] pend_dst,
  output logic              guard,
  output logic              retire,
  output logic              recent_vld,
  output logic [REG_AW-1:0] recent_dst,
  output logic              wb_fire
);
  logic              pend_vld_q;
  logic [REG_AW-1:0] pend_dst_q;
  logic              drop_q;
  logic              guard_q;
  logic              recent_vld_q;
  logic [REG_AW-1:0] recent_dst_q;
  logic              waw_hit;

  assign waw_hit = pend_vld_q & rf_wb_vld & (rf_wb_dst == pend_dst_q);
  assign retire  = pend_vld_q & rvalid;
  assign wb_fire = retire & (|pend_dst_q) & ~drop_q & ~waw_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld_q   <= 1'b0;
      pend_dst_q   <= '0;
      drop_q       <= 1'b0;
      guard_q      <= 1'b0;
      recent_vld_q <= 1'b0;
      recent_dst_q <= '0;
    end else begin
      guard_q      <= start;
      recent_vld_q <= retire;
      recent_dst_q <= pend_dst_q;
      if (start) begin
        pend_vld_q <= 1'b1;
        pend_dst_q <= start_dst;
        drop_q     <= 1'b0;
      end else begin
        if (retire)  pend_vld_q <= 1'b0;
        if (waw_hit) drop_q     <= 1'b1;
      end
    end
  end

  assign pend_vld   = pend_vld_q;
  assign pend_dst   = pend_dst_q;
  assign guard      = guard_q;
  assign recent_vld = recent_vld_q;
  assign recent_dst = recent_dst_q;
endmodule

// File: rtl/lic_src_match.sv
module lic_src_match #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                      pend_vld,
  input  logic [REG_AW-1:0]         pend_dst,
  input  logic [NUM_SRC-1:0]        src_vld,
  input  logic [NUM_SRC*REG_AW-1:0] src_idx,
  output logic                      hit
);
  logic [NUM_SRC-1:0] per_src;
  logic               live;

  assign live = pend_vld & (|pend_dst);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign per_src[g] = live & src_vld[g] &
                        (src_idx[g*REG_AW +: REG_AW] == pend_dst);
  end

  assign hit = |per_src;
endmodule

// File: rtl/lic_hold_arb.sv
module lic_hold_arb
  import lic_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              guard,
  input  logic              retire,
  input  logic              dep_hit,
  input  logic              pend_vld,
  input  logic              ex_ld_vld,
  input  logic [REG_AW-1:0] ex_ld_dst,
  input  logic              recent_vld,
  input  logic [REG_AW-1:0] recent_dst,
  output hold_why_t         why,
  output logic              hold
);
  always_comb begin
    why.guard = guard;
    why.ret   = retire;
    why.dep   = dep_hit;
    why.busy  = ex_ld_vld & pend_vld;
    why.space = ex_ld_vld & recent_vld & (|ex_ld_dst) &
                (ex_ld_dst == recent_dst);
  end

  assign hold = |why;
endmodule

// File: rtl/load_interlock_ctrl.sv
module load_interlock_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned REG_AW  = LIC_REG_AW,
  parameter int unsigned NUM_SRC = LIC_NUM_SRC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ex_ld_vld,
  input  logic [REG_AW-1:0]         ex_ld_dst,
  input  logic                      mem_rvalid,
  input  logic [NUM_SRC-1:0]        dec_src_vld,
  input  logic [NUM_SRC*REG_AW-1:0] dec_src_idx,
  input  logic                      rf_wb_vld,
  input  logic [REG_AW-1:0]         rf_wb_dst,
  output logic                      stall,
  output logic                      ld_wb_en,
  output logic [REG_AW-1:0]         ld_wb_idx
);
  logic              ld_start;
  logic              pend_vld;
  logic [REG_AW-1:0] pend_dst;
  logic              guard;
  logic              retire;
  logic              recent_vld;
  logic [REG_AW-1:0] recent_dst;
  logic              wb_fire;
  logic              dep_hit;
  hold_why_t         why;
  logic              hold;

  // A load leaves execute only in a cycle the pipe is not held.
  assign ld_start = ex_ld_vld & ~hold;

  lic_pend_track #(.REG_AW(REG_AW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ld_start),
    .start_dst  (ex_ld_dst),
    .rvalid     (mem_rvalid),
    .rf_wb_vld  (rf_wb_vld),
    .rf_wb_dst  (rf_wb_dst),
    .pend_vld   (pend_vld),
    .pend_dst   (pend_dst),
    .guard      (guard),
    .retire     (retire),
    .recent_vld (recent_vld),
    .recent_dst (recent_dst),
    .wb_fire    (wb_fire)
  );

  lic_src_match #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_match (
    .pend_vld (pend_vld),
    .pend_dst (pend_dst),
    .src_vld  (dec_src_vld),
    .src_idx  (dec_src_idx),
    .hit      (dep_hit)
  );

  lic_hold_arb #(.REG_AW(REG_AW)) u_arb (
    .guard      (guard),
    .retire     (retire),
    .dep_hit    (dep_hit),
    .pend_vld   (pend_vld),
    .ex_ld_vld  (ex_ld_vld),
    .ex_ld_dst  (ex_ld_dst),
    .recent_vld (recent_vld),
    .recent_dst (recent_dst),
    .why        (why),
    .hold       (hold)
  );

  assign stall     = hold;
  assign ld_wb_en  = wb_fire;
  assign ld_wb_idx = pend_dst;
endmodule

// File: rtl/lic_chk.sv
module lic_chk #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ex_ld_vld,
  input logic [REG_AW-1:0]         ex_ld_dst,
  input logic                      mem_rvalid,
  input logic [NUM_SRC-1:0]        dec_src_vld,
  input logic [NUM_SRC*REG_AW-1:0] dec_src_idx,
  input logic                      stall,
  input logic                      ld_wb_en,
  input logic [REG_AW-1:0]         ld_wb_idx
);
  logic              go;
  logic              out_q;
  logic [REG_AW-1:0] out_dst;

  assign go = ex_ld_vld & ~stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      out_dst <= '0;
    end else if (go) begin
      out_q   <= 1'b1;
      out_dst <= ex_ld_dst;
    end else if (mem_rvalid) begin
      out_q   <= 1'b0;
    end
  end

  // R2
  guard_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> stall);

  // R3
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && mem_rvalid) |-> stall);

  // R3
  wb_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wb_en |-> (out_q && mem_rvalid && ld_wb_idx == out_dst));

  // R7
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !out_q);

  // R9
  no_zero_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wb_en |-> (ld_wb_idx != '0));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dep
    // R4
    dep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q && out_dst != '0 && dec_src_vld[g] &&
       dec_src_idx[g*REG_AW +: REG_AW] == out_dst) |-> stall);
  end
endmodule

bind load_interlock_ctrl lic_chk #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_ld_vld   (ex_ld_vld),
  .ex_ld_dst   (ex_ld_dst),
  .mem_rvalid  (mem_rvalid),
  .dec_src_vld (dec_src_vld),
  .dec_src_idx (dec_src_idx),
  .stall       (stall),
  .ld_wb_en    (ld_wb_en),
  .ld_wb_idx   (ld_wb_idx)
);

// File: tb/load_interlock_ctrl_tb_top.sv
module load_interlock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 6;
  localparam int WD_CYCLES  = 150000;
  localparam int PMAX       = 32;
  localparam int K_NOP = 0, K_ALU = 1, K_LD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_ld_vld = 1'b0;
  logic [4:0]  ex_ld_dst = '0;
  logic        mem_rvalid = 1'b0;
  logic [1:0]  dec_src_vld = '0;
  logic [9:0]  dec_src_idx = '0;
  logic        rf_wb_vld = 1'b0;
  logic [4:0]  rf_wb_dst = '0;
  logic        stall;
  logic        ld_wb_en;
  logic [4:0]  ld_wb_idx;

  int checks = 0;
  int failures = 0;

  int p_kind [PMAX];
  int p_dst  [PMAX];
  int p_s1   [PMAX];
  int p_s2   [PMAX];
  bit p_v1   [PMAX];
  bit p_v2   [PMAX];
  int p_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_interlock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ex_ld_vld(ex_ld_vld), .ex_ld_dst(ex_ld_dst),
    .mem_rvalid(mem_rvalid), .dec_src_vld(dec_src_vld), .dec_src_idx(dec_src_idx),
    .rf_wb_vld(rf_wb_vld), .rf_wb_dst(rf_wb_dst), .stall(stall),
    .ld_wb_en(ld_wb_en), .ld_wb_idx(ld_wb_idx)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int i, input int k, input int d,
                     input int s1, input bit v1, input int s2, input bit v2);
    p_kind[i] = k; p_dst[i] = d; p_s1[i] = s1; p_v1[i] = v1;
    p_s2[i] = s2; p_v2[i] = v2;
  endtask

  function automatic int pick_other(input int avoid);
    int r;
    r = avoid;
    while (r == avoid) r = 1 + int'($urandom_range(30));
    return r;
  endfunction

  // Expected stall cycles for one load whose first reader sits d behind it.
  function automatic int exp_stalls(input bit dep, input int d);
    if (dep && d >= 1 && d <= 5) return 7 - d;
    return 2;
  endfunction

  // One load, d independent fillers, then a reader (of ldst if dep).
  task automatic build_use(input int ldst, input int d, input bit dep);
    int o;
    put(0, K_LD, ldst, 0, 1'b0, 0, 1'b0);
    for (int i = 1; i <= d; i++)
      put(i, K_ALU, pick_other(ldst), pick_other(ldst), 1'b1, pick_other(ldst), 1'b1);
    o = pick_other(ldst);
    put(d + 1, K_ALU, pick_other(ldst), o, 1'b1, dep ? ldst : pick_other(ldst), 1'b1);
    put(d + 2, K_NOP, 0, 0, 1'b0, 0, 1'b0);
    p_n = d + 3;
  endtask

  // Steps the modelled pipe through the program until it drains.
  task automatic run_prog(output int stalls, output int wbs, output int bad_idx);
    int  di, ei, tmr, cur;
    bit  ev, armed, wbp;
    int  wbd;
    di = 0; ei = 0; tmr = 0; cur = 0; ev = 0; armed = 0; wbp = 0; wbd = 0;
    stalls = 0; wbs = 0; bad_idx = 0;
    while (di < p_n || ev || armed || wbp) begin
      @(negedge clk);
      if (armed && tmr > 0) tmr--;
      mem_rvalid = armed && (tmr == 0);
      rf_wb_vld  = wbp;
      rf_wb_dst  = 5'(wbd);
      ex_ld_vld  = ev && (p_kind[ei] == K_LD);
      ex_ld_dst  = ev ? 5'(p_dst[ei]) : 5'd0;
      if (di < p_n) begin
        dec_src_vld = {p_v2[di], p_v1[di]};
        dec_src_idx = {5'(p_s2[di]), 5'(p_s1[di])};
      end else begin
        dec_src_vld = '0;
        dec_src_idx = '0;
      end
      #1;
      if (stall) stalls++;
      if (ld_wb_en) begin
        wbs++;
        if (int'(ld_wb_idx) != cur) bad_idx++;
      end
      if (mem_rvalid) armed = 0;
      wbp = 0;
      if (!stall) begin
        if (ev && p_kind[ei] == K_LD) begin
          armed = 1; tmr = MEM_LAT; cur = p_dst[ei];
        end
        if (ev && p_kind[ei] == K_ALU && p_dst[ei] != 0) begin
          wbp = 1; wbd = p_dst[ei];
        end
        if (di < p_n) begin ei = di; ev = 1; di++; end
        else ev = 0;
      end
    end
    @(negedge clk);
    mem_rvalid = 0; rf_wb_vld = 0; ex_ld_vld = 0; dec_src_vld = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=%0d expected=0", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int st, wb, bad;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check("R1", "stall in reset", int'(stall), 0);
    check("R1", "ld_wb_en in reset", int'(ld_wb_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "stall after reset", int'(stall), 0);
    check("R1", "ld_wb_en after reset", int'(ld_wb_en), 0);

    // R5 R6 R2 R3 R4: cost against load-to-use distance 0..6
    for (int d = 0; d <= 6; d++) begin
      build_use(7, d, 1'b1);
      run_prog(st, wb, bad);
      check(d == 0 ? "R5" : "R6", $sformatf("load cost at distance %0d", d),
            st + 1, (d >= 1 && d <= 5) ? 8 - d : 3);
      check("R3", $sformatf("load writes at distance %0d", d), wb, 1);
      check("R3", "load write index", bad, 0);
    end

    // R6: no reader at all
    build_use(12, 7, 1'b0);
    run_prog(st, wb, bad);
    check("R6", "load cost with no reader", st + 1, 3);

    // R7: three loads, distinct destinations
    put(0, K_LD, 4, 0, 0, 0, 0); put(1, K_LD, 5, 0, 0, 0, 0);
    put(2, K_LD, 6, 0, 0, 0, 0); put(3, K_NOP, 0, 0, 0, 0, 0); p_n = 4;
    run_prog(st, wb, bad);
    check("R7", "stalls for distinct back-to-back loads", st, 14);
    check("R7", "writes for distinct loads", wb, 3);
    check("R7", "write index order", bad, 0);

    // R8: three loads, one destination
    put(0, K_LD, 4, 0, 0, 0, 0); put(1, K_LD, 4, 0, 0, 0, 0);
    put(2, K_LD, 4, 0, 0, 0, 0); put(3, K_NOP, 0, 0, 0, 0, 0); p_n = 4;
    run_prog(st, wb, bad);
    check("R8", "stalls for same-register back-to-back loads", st, 16);
    check("R8", "writes for same-register loads", wb, 3);

    // R9: load to register 0 with an immediate reader of register 0
    put(0, K_LD, 0, 0, 0, 0, 0); put(1, K_ALU, 3, 0, 0, 0, 0);
    put(2, K_ALU, 8, 0, 1, 0, 1); put(3, K_NOP, 0, 0, 0, 0, 0); p_n = 4;
    run_prog(st, wb, bad);
    check("R9", "stalls for load to register 0", st, 2);
    check("R9", "writes for load to register 0", wb, 0);

    // R10: delay-slot instruction overwrites the load's destination
    put(0, K_LD, 9, 0, 0, 0, 0); put(1, K_ALU, 9, 2, 1, 3, 1);
    put(2, K_NOP, 0, 0, 0, 0, 0); p_n = 3;
    run_prog(st, wb, bad);
    check("R10", "load write after younger writeback", wb, 0);
    check("R10", "stalls still taken", st, 2);

    // R4 R5 R6: random distances, registers and dependence
    for (int k = 0; k < 40; k++) begin
      int  d, ld;
      bit  dep;
      d   = int'($urandom_range(8));
      ld  = 1 + int'($urandom_range(30));
      dep = 1'($urandom_range(1));
      build_use(ld, d, dep);
      run_prog(st, wb, bad);
      check("R4", $sformatf("random load r%0d d=%0d dep=%0d stalls", ld, d, dep),
            st, exp_stalls(dep, d));
      check("R3", "random load write index", bad, 0);
    end

    summary();
    $finish;
  end
endmodule